// File: doc/BRIEF.md
# Processor Execution Mode Controller

This block holds the processor's current execution and addressing mode, which is one of slave, master or absolute. On each cycle the decoder hands it the qualifiers of the instruction that is executing: whether the instruction is privileged, its interrupt-inhibit bit (bit 28), its base-addressing bit (bit 29), whether it is a transfer, and whether that transfer's operand address was formed by appending. The block also receives fault and interrupt events, and a master flag taken from the target segment's descriptor.

From these inputs it reports the mode, raises an illegal-procedure fault when slave code tries to run a privileged instruction, and gives the interrupt inhibit that takes effect. It also tells the address path whether instruction fetch and operand fetch use absolute or appended address formation. Any fault or interrupt moves the block into absolute mode. The block leaves absolute mode only through a transfer whose operand address was appended, and it then enters master or slave as the descriptor's flag selects. Opcode decoding, address arithmetic and memory access belong to other blocks.

Top module: `exec_mode_ctrl`

## Requirements
- R1: In the clock cycle after a cycle with `rst_n` low, `mode` is absolute and `illegal_proc` and `inhibit_eff` are 0. The mode encoding is slave = 2'b00, master = 2'b01, absolute = 2'b10.
- R2: A valid privileged instruction in slave mode drives `illegal_proc` high in the same cycle, and `mode` is absolute on the next cycle.
- R3: A valid privileged instruction in master or absolute mode never drives `illegal_proc`.
- R4: `inhibit_eff` follows the inhibit bit of a valid instruction in master and absolute modes, and is 0 in slave mode whatever that bit is.
- R5: When `fault_evt` or `intr_evt` is high, `mode` is absolute on the next cycle. This holds even when an appended transfer is present in the same cycle.
- R6: In absolute mode, `mode` changes only on a valid transfer with `xfer_appended` high. It then goes to master if `seg_master` is 1 and to slave if it is 0. A transfer without an appended operand leaves absolute mode in place.
- R7: In master or slave mode, `mode` holds its value unless a fault, an interrupt or an illegal-procedure fault occurs. Appended transfers do not change it.
- R8: An instruction that raises `illegal_proc` commits no mode change of its own. A privileged appended transfer in slave mode leads to absolute mode, whatever `seg_master` is.
- R9: `ifetch_abs` is 1 exactly when `mode` is absolute.
- R10: `opnd_abs` is the inverse of `instr_base_sel` in absolute mode and is 0 in master and slave modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_priv | input | 1 | Instruction is privileged |
| instr_inhibit | input | 1 | Interrupt-inhibit bit of the instruction (bit 28) |
| instr_base_sel | input | 1 | Base-addressing bit of the instruction (bit 29) |
| instr_xfer | input | 1 | Instruction is a transfer |
| xfer_appended | input | 1 | Transfer operand address was formed by appending |
| seg_master | input | 1 | Master flag from the target segment descriptor |
| fault_evt | input | 1 | A fault is taken this cycle |
| intr_evt | input | 1 | An interrupt is taken this cycle |
| mode | output | 2 | Current mode (00 slave, 01 master, 10 absolute) |
| illegal_proc | output | 1 | Illegal-procedure fault pulse |
| inhibit_eff | output | 1 | Interrupt inhibit that takes effect |
| ifetch_abs | output | 1 | Instruction fetch uses absolute addressing |
| opnd_abs | output | 1 | Operand fetch uses absolute addressing |

## Verification
On every cycle the assertions check the following: slave mode never lets an inhibit through, every fault, interrupt or illegal-procedure pulse is followed by absolute mode, absolute mode persists without an appended transfer, and master or slave persists without an event. The assertions also check that the fetch selects agree with the mode. Only the bench's scenarios can show which of master or slave is chosen when absolute mode is left. The same holds for the precedence of a fault over a same-cycle transfer, and for a faulting privileged transfer committing nothing. The complete mode walk from reset through each mode and back also needs the scenarios.

// File: rtl/exec_mode_pkg.sv
// Package: shared mode type and widths for the execution mode controller.
// Assumes: a two-bit mode code whose values are visible at the top ports.
package exec_mode_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SLAVE  = 2'b00,
        MODE_MASTER = 2'b01,
        MODE_ABS    = 2'b10
    } exec_mode_t;

endpackage

// File: rtl/exec_mode_priv.sv
// Module: privilege gate. Flags privileged instructions issued in slave mode
// and masks the interrupt-inhibit bit where slave mode forbids it.
// Assumes: the qualifiers are valid only while instr_valid is high.
module exec_mode_priv
    import exec_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  exec_mode_t cur_mode,
    input  logic       instr_valid,
    input  logic       instr_priv,
    input  logic       instr_inhibit,
    output logic       illegal_proc,
    output logic       inhibit_eff
);

    logic in_slave;

    // Decode whether the current mode is the unprivileged one.
    always_comb begin
        in_slave = (cur_mode == MODE_SLAVE);
    end

    // Raise the fault for privileged slave code and gate the inhibit bit.
    always_comb begin
        illegal_proc = instr_valid && instr_priv && in_slave;
        inhibit_eff  = instr_valid && instr_inhibit && !in_slave;
    end

    // R3: a privileged instruction in master or absolute mode is never a fault
    p_priv_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_SLAVE) |-> !illegal_proc);

    // R4: slave mode never lets an inhibit reach the interrupt logic
    p_no_slave_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLAVE) |-> !inhibit_eff);

endmodule

// File: rtl/exec_mode_state.sv
// Module: mode register and its next-state rules. Events force absolute mode.
// An appended transfer leaves absolute mode for the mode that the descriptor
// selects. A faulting instruction commits nothing.
// Assumes: illegal_hit comes from the privilege gate in the same cycle.
module exec_mode_state
    import exec_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_valid,
    input  logic       instr_xfer,
    input  logic       xfer_appended,
    input  logic       seg_master,
    input  logic       fault_evt,
    input  logic       intr_evt,
    input  logic       illegal_hit,
    output exec_mode_t cur_mode
);

    exec_mode_t next_mode;
    logic       force_abs;
    logic       leave_abs;

    // Classify this cycle's events.
    always_comb begin
        force_abs = fault_evt || intr_evt || illegal_hit;
        leave_abs = (cur_mode == MODE_ABS) && instr_valid && instr_xfer && xfer_appended;
    end

    // Pick the next mode: events first, then an exit from absolute mode, else hold.
    always_comb begin
        next_mode = cur_mode;
        if (force_abs) begin
            next_mode = MODE_ABS;
        end else if (leave_abs) begin
            next_mode = seg_master ? MODE_MASTER : MODE_SLAVE;
        end
    end

    // Mode register with synchronous reset into absolute mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= MODE_ABS;
        end else begin
            cur_mode <= next_mode;
        end
    end

    // R5: any fault or interrupt lands in absolute mode
    p_event_to_abs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_evt || intr_evt) |=> (cur_mode == MODE_ABS));

    // R2: an illegal-procedure fault is followed by absolute mode
    p_illegal_to_abs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_hit |=> (cur_mode == MODE_ABS));

    // R6: absolute mode persists without an appended transfer
    p_abs_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == MODE_ABS) && !(instr_valid && instr_xfer && xfer_appended))
        |=> (cur_mode == MODE_ABS));

    // R7: master and slave persist when no event occurs
    p_ms_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode != MODE_ABS) && !fault_evt && !intr_evt && !illegal_hit)
        |=> $stable(cur_mode));

endmodule

// File: rtl/exec_mode_addr_sel.sv
// Module: address-formation selects. Instruction fetch is absolute only in
// absolute mode. There, operand fetch follows the base-addressing bit.
// Assumes: appended formation is the default in master and slave modes.
module exec_mode_addr_sel
    import exec_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  exec_mode_t cur_mode,
    input  logic       instr_base_sel,
    output logic       ifetch_abs,
    output logic       opnd_abs
);

    logic abs_now;

    // Decode absolute mode once for both selects.
    always_comb begin
        abs_now = (cur_mode == MODE_ABS);
    end

    // Drive the fetch and operand selects.
    always_comb begin
        ifetch_abs = abs_now;
        opnd_abs   = abs_now && !instr_base_sel;
    end

    // R10: outside absolute mode operands are always appended
    p_opnd_append_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ifetch_abs |-> !opnd_abs);

    // R9: the fetch select agrees with the mode
    p_ifetch_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ifetch_abs == (cur_mode == MODE_ABS));

endmodule

// File: rtl/exec_mode_ctrl.sv
// Module: top of the execution mode controller. It ties the privilege gate,
// the mode register and the address selects together.
// Assumes: the qualifiers and events are synchronous to clk and settle before the edge.
module exec_mode_ctrl
    import exec_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              instr_priv,
    input  logic              instr_inhibit,
    input  logic              instr_base_sel,
    input  logic              instr_xfer,
    input  logic              xfer_appended,
    input  logic              seg_master,
    input  logic              fault_evt,
    input  logic              intr_evt,
    output logic [MODE_W-1:0] mode,
    output logic              illegal_proc,
    output logic              inhibit_eff,
    output logic              ifetch_abs,
    output logic              opnd_abs
);

    exec_mode_t cur_mode;
    logic       illegal_hit;

    exec_mode_priv u_priv (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_mode      (cur_mode),
        .instr_valid   (instr_valid),
        .instr_priv    (instr_priv),
        .instr_inhibit (instr_inhibit),
        .illegal_proc  (illegal_hit),
        .inhibit_eff   (inhibit_eff)
    );

    exec_mode_state u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_xfer    (instr_xfer),
        .xfer_appended (xfer_appended),
        .seg_master    (seg_master),
        .fault_evt     (fault_evt),
        .intr_evt      (intr_evt),
        .illegal_hit   (illegal_hit),
        .cur_mode      (cur_mode)
    );

    exec_mode_addr_sel u_addr (
        .clk            (clk),
        .rst_n          (rst_n),
        .cur_mode       (cur_mode),
        .instr_base_sel (instr_base_sel),
        .ifetch_abs     (ifetch_abs),
        .opnd_abs       (opnd_abs)
    );

    // Expose the mode code and the fault pulse.
    always_comb begin
        mode         = cur_mode;
        illegal_proc = illegal_hit;
    end

    // R8: a faulting instruction never lands outside absolute mode
    p_fault_commits_nothing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_proc |=> (mode == 2'b10));

endmodule

// File: tb/test_exec_mode_ctrl.sv
// Directed bench for exec_mode_ctrl. There is one task per scenario, and each task checks its own results.
module test_exec_mode_ctrl;

    localparam logic [1:0] SLV = 2'b00;
    localparam logic [1:0] MST = 2'b01;
    localparam logic [1:0] ABS = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0, instr_priv = 1'b0, instr_inhibit = 1'b0;
    logic       instr_base_sel = 1'b0, instr_xfer = 1'b0, xfer_appended = 1'b0;
    logic       seg_master = 1'b0, fault_evt = 1'b0, intr_evt = 1'b0;
    logic [1:0] mode;
    logic       illegal_proc, inhibit_eff, ifetch_abs, opnd_abs;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    exec_mode_ctrl i_exec_mode_ctrl (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_priv(instr_priv),
        .instr_inhibit(instr_inhibit), .instr_base_sel(instr_base_sel),
        .instr_xfer(instr_xfer), .xfer_appended(xfer_appended),
        .seg_master(seg_master), .fault_evt(fault_evt), .intr_evt(intr_evt),
        .mode(mode), .illegal_proc(illegal_proc), .inhibit_eff(inhibit_eff),
        .ifetch_abs(ifetch_abs), .opnd_abs(opnd_abs)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        instr_valid = 0; instr_priv = 0; instr_inhibit = 0; instr_base_sel = 0;
        instr_xfer = 0; xfer_appended = 0; seg_master = 0; fault_evt = 0; intr_evt = 0;
    endtask

    // Wait one edge, then settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Drive an appended transfer from absolute mode into master or slave.
    task automatic go_mode(input logic to_master);
        idle();
        instr_valid = 1; instr_xfer = 1; xfer_appended = 1; seg_master = to_master;
        tick();
        idle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        idle();
        tick(); tick();
        #1;
        check("R1 mode", mode, ABS);
        check("R1 illegal", illegal_proc, 0);
        check("R1 inhibit", inhibit_eff, 0);
        rst_n = 1;
        tick();
    endtask

    task automatic t_abs_exit();
        instr_valid = 1; instr_xfer = 1; xfer_appended = 0; seg_master = 1;
        tick();
        check("R6 unappended xfer stays abs", mode, ABS);
        go_mode(1);
        check("R6 exit to master", mode, MST);
        fault_evt = 1; tick(); idle();
        check("R5 fault to abs", mode, ABS);
        go_mode(0);
        check("R6 exit to slave", mode, SLV);
    endtask

    task automatic t_slave_priv();
        // Already in slave mode.
        instr_valid = 1; instr_priv = 1; instr_inhibit = 1;
        #1;
        check("R2 illegal pulse", illegal_proc, 1);
        check("R4 slave inhibit masked", inhibit_eff, 0);
        tick(); idle(); #1;
        check("R2 abs after fault", mode, ABS);
        check("R2 pulse one cycle", illegal_proc, 0);
    endtask

    task automatic t_priv_ok();
        instr_valid = 1; instr_priv = 1; instr_inhibit = 1;
        #1;
        check("R3 abs priv ok", illegal_proc, 0);
        check("R4 abs inhibit", inhibit_eff, 1);
        idle();
        go_mode(1);
        instr_valid = 1; instr_priv = 1; instr_inhibit = 1;
        #1;
        check("R3 master priv ok", illegal_proc, 0);
        check("R4 master inhibit", inhibit_eff, 1);
        instr_inhibit = 0; #1;
        check("R4 master no inhibit", inhibit_eff, 0);
        tick(); idle();
        check("R7 master holds", mode, MST);
    endtask

    task automatic t_ms_hold();
        // Master: an appended transfer to a slave segment keeps master.
        instr_valid = 1; instr_xfer = 1; xfer_appended = 1; seg_master = 0;
        tick(); idle();
        check("R7 master ignores xfer", mode, MST);
        intr_evt = 1; tick(); idle();
        check("R5 interrupt to abs", mode, ABS);
        go_mode(0);
        instr_valid = 1; instr_xfer = 1; xfer_appended = 1; seg_master = 1;
        tick(); idle();
        check("R7 slave ignores xfer", mode, SLV);
    endtask

    task automatic t_fault_priority();
        // In slave: a privileged appended transfer faults and commits nothing.
        instr_valid = 1; instr_priv = 1; instr_xfer = 1; xfer_appended = 1; seg_master = 1;
        tick(); idle();
        check("R8 faulting xfer to abs", mode, ABS);
        // In abs: a fault beats an appended transfer in the same cycle.
        instr_valid = 1; instr_xfer = 1; xfer_appended = 1; seg_master = 1; fault_evt = 1;
        tick(); idle();
        check("R5 fault beats xfer", mode, ABS);
    endtask

    task automatic t_addr_sel();
        instr_valid = 1; instr_base_sel = 0; #1;
        check("R9 abs ifetch", ifetch_abs, 1);
        check("R10 abs operand absolute", opnd_abs, 1);
        instr_base_sel = 1; #1;
        check("R10 abs operand appended", opnd_abs, 0);
        idle();
        go_mode(1);
        instr_valid = 1; instr_base_sel = 0; #1;
        check("R9 master ifetch", ifetch_abs, 0);
        check("R10 master operand", opnd_abs, 0);
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_abs_exit();
        t_slave_priv();
        t_priv_ok();
        t_ms_hold();
        t_fault_priority();
        t_addr_sel();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule